// File: doc/BRIEF.md
# Timing Reference Selector with Holdover Supervision

This block supervises a small set of timing reference inputs, such as a once-per-second marker, a divided external reference and local oscillator ticks. Each input is a single-cycle marker strobe, synchronous to the local clock. The block checks the spacing between consecutive markers against a programmable expected period and tolerance window. An input that keeps correct spacing for a programmable number of intervals becomes qualified. A qualified input that misses its window, or goes silent for too long, loses qualification at once.

A timebase state machine picks the qualified input with the lowest index, which is the highest priority. The state is always one of three values. HOLDOVER means the local oscillator runs alone. SWITCH is a short settling interval on the new source. LOCK means the block follows the selected source. A software force can pin the selection to a chosen qualified input.

Every state change is written into a small event FIFO as a tagged entry. The entry holds a timestamp and a reason code. Counters record holdover entries, switches and cumulative holdover time. All of these are read through a simple register port, and the reason for the latest switch is kept in its own register.

Top module: `refsel_holdover`

## Requirements
- R1: The `tbState` output always carries one of three codes: 0 = HOLDOVER, 1 = LOCK, 2 = SWITCH. After reset it is HOLDOVER, `selRef` is 0, and every counter and the log are empty.
- R2: An input becomes qualified only after one first marker and then `qualCount` consecutive marker intervals within period ± window. The period is at register 0x0, the window at 0x1 and the count at 0x2, all counted in clock cycles. An interval outside that range, or a gap longer than period + window, removes qualification, so an input ticking at a wrong rate never gets selected.
- R3: When the selected input loses qualification and another input is qualified, the block enters SWITCH toward the lowest-index qualified input, with reason 0.
- R4: When the selected input is lost and no input is qualified, the block enters HOLDOVER. The holdover-time counter (register 0x6) rises by one in every cycle spent in HOLDOVER and stays frozen in every other state.
- R5: SWITCH lasts exactly 4 cycles, after which the state becomes LOCK on the new source.
- R6: Writing an input index to register 0x3 (bits [1:0]) switches to that input with reason 2, provided the input is qualified and differs from the current one. The selection then stays pinned against preemption. A force toward an unqualified input has no effect.
- R7: Each state change pushes one log entry, read at register 0x9. The entry fields are: bit 31 = entry valid, [29:28] = reason, [27:26] = new state, [25:24] = new input index, [23:0] = timestamp of the cycle that decided the change. Reason codes are 0 = lost signal, 1 = higher-priority source valid, 2 = forced, 3 = switch settled.
- R8: Three counters are kept. Register 0x4 counts holdover entries and register 0x5 counts entries into SWITCH. Register 0x7 holds the reason of the most recent switch.
- R9: The log FIFO holds 4 entries. An entry arriving while the FIFO is full and not being read is dropped, and it sets a sticky overflow flag. Register 0x8 shows the overflow flag in bit 8 and the entry count in bits [2:0], and reading it clears the flag. Reading 0x9 pops the oldest entry and returns 0 when the FIFO is empty. A pop and a push in the same cycle on a full FIFO both take effect.
- R10: In LOCK on an unpinned source, a qualified input with a lower index causes a switch to that input with reason 1. Leaving HOLDOVER because an input qualified also uses reason 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local oscillator clock |
| rstN | input | 1 | Active-low synchronous reset |
| refTick | input | NUM_REFS | One-cycle marker strobe per reference input, index 0 highest priority |
| regAddr | input | 4 | Register address |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (pops the log or clears overflow) |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data, combinational from regAddr |
| tbState | output | 2 | Timebase state: 0 HOLDOVER, 1 LOCK, 2 SWITCH |
| selRef | output | 2 | Index of the selected or last selected input |

## Verification
The log FIFO can receive a push, from the switch-settled event, in the same cycle that software pops it through a read of the log register. The bench fills the FIFO to its depth and forces a switch. A forced switch decides its event in the write cycle, so the settle event falls exactly four cycles later, and the log read is placed in that cycle. The result is judged by three things: the count stays at four, the read returns the oldest entry, and the newly pushed settle entry appears at the tail while the earlier push from the forced switch is dropped.

// File: rtl/refsel_pkg.sv
package refsel_pkg;
  typedef enum logic [1:0] {
    TB_HOLD   = 2'd0,
    TB_LOCK   = 2'd1,
    TB_SWITCH = 2'd2
  } tbState_e;

  localparam logic [1:0] RSN_LOST    = 2'd0;
  localparam logic [1:0] RSN_BETTER  = 2'd1;
  localparam logic [1:0] RSN_FORCED  = 2'd2;
  localparam logic [1:0] RSN_SETTLED = 2'd3;

  // Strobes passed from the state machine to the datapath.
  typedef struct packed {
    logic       logEvt;
    logic [1:0] reason;
    logic [1:0] newState;
    logic [1:0] newRef;
  } ctrlStrobe_t;
endpackage

// File: rtl/ref_qualifier.sv
module ref_qualifier #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic [CNT_W-1:0] periodCfg,
  input  logic [CNT_W-1:0] windowCfg,
  input  logic [CNT_W-1:0] qualCfg,
  output logic             qualified
);
  logic [CNT_W-1:0] gapCnt, goodCnt;
  logic             seenFirst;
  logic [CNT_W:0]   hiLim, loLim, gapWide, qualNeed;
  logic             inWindow, timedOut;

  always_comb begin
    hiLim    = {1'b0, periodCfg} + {1'b0, windowCfg};
    loLim    = (periodCfg > windowCfg) ? ({1'b0, periodCfg} - {1'b0, windowCfg}) : '0;
    gapWide  = {1'b0, gapCnt};
    inWindow = (gapWide >= loLim) && (gapWide <= hiLim);
    timedOut = gapWide > hiLim;
    qualNeed = (qualCfg == '0) ? (CNT_W+1)'(1) : {1'b0, qualCfg};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gapCnt    <= '0;
      goodCnt   <= '0;
      seenFirst <= 1'b0;
      qualified <= 1'b0;
    end else if (tick) begin
      gapCnt    <= (CNT_W)'(1);
      seenFirst <= 1'b1;
      if (seenFirst && inWindow) begin
        if ({1'b0, goodCnt} < qualNeed) goodCnt <= goodCnt + 1'b1;
        if (({1'b0, goodCnt} + 1'b1) >= qualNeed) qualified <= 1'b1;
      end else begin
        goodCnt   <= '0;
        qualified <= 1'b0;
      end
    end else begin
      if (gapCnt != '1) gapCnt <= gapCnt + 1'b1;
      if (seenFirst && timedOut) begin
        seenFirst <= 1'b0;
        goodCnt   <= '0;
        qualified <= 1'b0;
      end
    end
  end

  // R2: a silent input drops qualification one cycle after the limit is passed
  assert_timeout_drop_R2: assert property (@(posedge clk) disable iff (!rstN)
    (seenFirst && !tick && timedOut) |=> !qualified);
  // R2: qualification is only ever gained on a marker
  assert_qual_tick_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(qualified) |-> $past(tick));
endmodule

// File: rtl/refsel_ctrl.sv
module refsel_ctrl
  import refsel_pkg::*;
#(
  parameter int NUM_REFS  = 3,
  parameter int SW_CYCLES = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_REFS-1:0] qualVec,
  input  logic                forceReq,
  input  logic [1:0]          forceIdx,
  output tbState_e            state,
  output logic [1:0]          selRef,
  output ctrlStrobe_t         strobe
);
  localparam int SWC_W = $clog2(SW_CYCLES + 1);

  tbState_e        nextState;
  logic [1:0]      nextSel;
  logic            pinned, nextPinned, evt;
  logic [1:0]      reason;
  logic [SWC_W-1:0] swCnt;
  logic [3:0]      qualPad;
  logic [NUM_REFS-1:0] higher;
  logic            forceOk;

  function automatic logic [1:0] bestOf(input logic [NUM_REFS-1:0] m);
    logic [1:0] r = '0;
    for (int i = NUM_REFS - 1; i >= 0; i--) if (m[i]) r = 2'(i);
    return r;
  endfunction

  always_comb begin
    qualPad = 4'(qualVec);
    for (int i = 0; i < NUM_REFS; i++) higher[i] = (2'(i) < selRef);
    forceOk = forceReq && qualPad[forceIdx];
  end

  always_comb begin
    nextState  = state;
    nextSel    = selRef;
    nextPinned = pinned;
    evt        = 1'b0;
    reason     = RSN_LOST;
    case (state)
      TB_HOLD: begin
        if (forceOk) begin
          nextState = TB_SWITCH; nextSel = forceIdx; nextPinned = 1'b1;
          evt = 1'b1; reason = RSN_FORCED;
        end else if (|qualVec) begin
          nextState = TB_SWITCH; nextSel = bestOf(qualVec); nextPinned = 1'b0;
          evt = 1'b1; reason = RSN_BETTER;
        end
      end
      TB_LOCK: begin
        if (!qualPad[selRef]) begin
          nextPinned = 1'b0; evt = 1'b1; reason = RSN_LOST;
          if (|qualVec) begin
            nextState = TB_SWITCH; nextSel = bestOf(qualVec);
          end else begin
            nextState = TB_HOLD;
          end
        end else if (forceOk && forceIdx != selRef) begin
          nextState = TB_SWITCH; nextSel = forceIdx; nextPinned = 1'b1;
          evt = 1'b1; reason = RSN_FORCED;
        end else if (!pinned && |(qualVec & higher)) begin
          nextState = TB_SWITCH; nextSel = bestOf(qualVec & higher);
          evt = 1'b1; reason = RSN_BETTER;
        end
      end
      TB_SWITCH: begin
        if (!qualPad[selRef]) begin
          nextState = TB_HOLD; nextPinned = 1'b0; evt = 1'b1; reason = RSN_LOST;
        end else if (swCnt == SWC_W'(SW_CYCLES - 1)) begin
          nextState = TB_LOCK; evt = 1'b1; reason = RSN_SETTLED;
        end
      end
      default: begin
        nextState = TB_HOLD; evt = 1'b1; reason = RSN_LOST;
      end
    endcase
    strobe.logEvt   = evt;
    strobe.reason   = reason;
    strobe.newState = nextState;
    strobe.newRef   = nextSel;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= TB_HOLD;
      selRef <= '0;
      pinned <= 1'b0;
      swCnt  <= '0;
    end else begin
      state  <= nextState;
      selRef <= nextSel;
      pinned <= nextPinned;
      swCnt  <= (state == TB_SWITCH && nextState == TB_SWITCH) ? swCnt + 1'b1 : '0;
    end
  end

  // R1: only the three defined state codes appear
  assert_state_legal_R1: assert property (@(posedge clk) disable iff (!rstN)
    state inside {TB_HOLD, TB_LOCK, TB_SWITCH});
  // R4: a lost source never keeps the block in LOCK
  assert_lock_loss_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == TB_LOCK && !qualPad[selRef]) |=> state != TB_LOCK);
  // R5: LOCK is reached from SWITCH only after the full settling interval
  assert_switch_len_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state == TB_LOCK && $past(state) == TB_SWITCH) |-> $past(swCnt) == SWC_W'(SW_CYCLES - 1));
  // R6: a pinned, healthy source is not preempted
  assert_pinned_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == TB_LOCK && pinned && qualPad[selRef] && !forceReq) |=> (state == TB_LOCK && $stable(selRef)));
endmodule

// File: rtl/refsel_dp.sv
module refsel_dp
  import refsel_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int TS_W       = 24,
  parameter int HT_W       = 32,
  parameter int LOG_DEPTH  = 4,
  parameter int DEF_PERIOD = 1000,
  parameter int DEF_WINDOW = 8,
  parameter int DEF_QUAL   = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobe,
  input  tbState_e         state,
  input  logic [3:0]       regAddr,
  input  logic             regWr,
  input  logic             regRd,
  input  logic [31:0]      regWdata,
  output logic [31:0]      regRdata,
  output logic [CNT_W-1:0] periodCfg,
  output logic [CNT_W-1:0] windowCfg,
  output logic [CNT_W-1:0] qualCfg,
  output logic             forceReq,
  output logic [1:0]       forceIdx
);
  localparam int PTR_W = $clog2(LOG_DEPTH);
  localparam int ENT_W = 6 + TS_W;

  logic [TS_W-1:0]  tsCnt;
  logic [CNT_W-1:0] holdEntries, switchCount;
  logic [HT_W-1:0]  holdTime;
  logic [1:0]       lastReason;
  logic [ENT_W-1:0] logMem [LOG_DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [PTR_W:0]   logCnt;
  logic             ovf, full, pop, push, dropEvt, clrOvf;
  logic             unusedWdata;

  assign unusedWdata = ^regWdata;
  assign forceReq = regWr && regAddr == 4'h3;
  assign forceIdx = regWdata[1:0];
  assign full     = logCnt == (PTR_W+1)'(LOG_DEPTH);
  assign pop      = regRd && regAddr == 4'h9 && logCnt != '0;
  assign push     = strobe.logEvt && (!full || pop);
  assign dropEvt  = strobe.logEvt && full && !pop;
  assign clrOvf   = regRd && regAddr == 4'h8;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      periodCfg <= CNT_W'(DEF_PERIOD);
      windowCfg <= CNT_W'(DEF_WINDOW);
      qualCfg   <= CNT_W'(DEF_QUAL);
    end else if (regWr) begin
      case (regAddr)
        4'h0: periodCfg <= regWdata[CNT_W-1:0];
        4'h1: windowCfg <= regWdata[CNT_W-1:0];
        4'h2: qualCfg   <= regWdata[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tsCnt       <= '0;
      holdEntries <= '0;
      switchCount <= '0;
      holdTime    <= '0;
      lastReason  <= '0;
    end else begin
      tsCnt <= tsCnt + 1'b1;
      if (state == TB_HOLD && holdTime != '1) holdTime <= holdTime + 1'b1;
      if (strobe.logEvt && strobe.newState == TB_HOLD && holdEntries != '1)
        holdEntries <= holdEntries + 1'b1;
      if (strobe.logEvt && strobe.newState == TB_SWITCH) begin
        if (switchCount != '1) switchCount <= switchCount + 1'b1;
        lastReason <= strobe.reason;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      logCnt <= '0;
      ovf    <= 1'b0;
    end else begin
      if (push) begin
        logMem[wrPtr] <= {strobe.reason, strobe.newState, strobe.newRef, tsCnt};
        wrPtr <= wrPtr + 1'b1;
      end
      if (pop) rdPtr <= rdPtr + 1'b1;
      logCnt <= logCnt + (PTR_W+1)'(push) - (PTR_W+1)'(pop);
      ovf    <= dropEvt | (ovf & !clrOvf);
    end
  end

  always_comb begin
    regRdata = '0;
    case (regAddr)
      4'h0: regRdata = 32'(periodCfg);
      4'h1: regRdata = 32'(windowCfg);
      4'h2: regRdata = 32'(qualCfg);
      4'h4: regRdata = 32'(holdEntries);
      4'h5: regRdata = 32'(switchCount);
      4'h6: regRdata = 32'(holdTime);
      4'h7: regRdata = 32'(lastReason);
      4'h8: begin
        regRdata[8]       = ovf;
        regRdata[PTR_W:0] = logCnt;
      end
      4'h9: if (logCnt != '0) begin
        regRdata[31]        = 1'b1;
        regRdata[ENT_W-1:0] = logMem[rdPtr];
      end
      default: ;
    endcase
  end

  // R9: the entry count never exceeds the FIFO depth
  assert_fifo_bound_R9: assert property (@(posedge clk) disable iff (!rstN)
    logCnt <= (PTR_W+1)'(LOG_DEPTH));
  // R9: an event meeting a full FIFO without a read leaves the overflow flag set
  assert_overflow_set_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.logEvt && full && !pop) |=> ovf);
  // R4: holdover time is frozen outside HOLDOVER
  assert_holdtime_frozen_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state != TB_HOLD) |=> $stable(holdTime));
  // R9: a lone pop removes exactly one entry
  assert_pop_count_R9: assert property (@(posedge clk) disable iff (!rstN)
    (pop && !push) |=> logCnt == $past(logCnt) - 1'b1);
endmodule

// File: rtl/refsel_holdover.sv
module refsel_holdover
  import refsel_pkg::*;
#(
  parameter int NUM_REFS   = 3,
  parameter int CNT_W      = 16,
  parameter int TS_W       = 24,
  parameter int LOG_DEPTH  = 4,
  parameter int SW_CYCLES  = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_REFS-1:0] refTick,
  input  logic [3:0]          regAddr,
  input  logic                regWr,
  input  logic                regRd,
  input  logic [31:0]         regWdata,
  output logic [31:0]         regRdata,
  output logic [1:0]          tbState,
  output logic [1:0]          selRef
);
  logic [CNT_W-1:0]    periodCfg, windowCfg, qualCfg;
  logic [NUM_REFS-1:0] qualVec;
  logic                forceReq;
  logic [1:0]          forceIdx;
  tbState_e            state;
  ctrlStrobe_t         strobe;

  for (genvar g = 0; g < NUM_REFS; g++) begin : g_qual
    ref_qualifier #(.CNT_W(CNT_W)) i_qual (
      .clk(clk), .rstN(rstN), .tick(refTick[g]),
      .periodCfg(periodCfg), .windowCfg(windowCfg), .qualCfg(qualCfg),
      .qualified(qualVec[g])
    );
  end

  refsel_ctrl #(.NUM_REFS(NUM_REFS), .SW_CYCLES(SW_CYCLES)) i_ctrl (
    .clk(clk), .rstN(rstN), .qualVec(qualVec), .forceReq(forceReq),
    .forceIdx(forceIdx), .state(state), .selRef(selRef), .strobe(strobe)
  );

  refsel_dp #(.CNT_W(CNT_W), .TS_W(TS_W), .LOG_DEPTH(LOG_DEPTH)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .state(state),
    .regAddr(regAddr), .regWr(regWr), .regRd(regRd), .regWdata(regWdata),
    .regRdata(regRdata), .periodCfg(periodCfg), .windowCfg(windowCfg),
    .qualCfg(qualCfg), .forceReq(forceReq), .forceIdx(forceIdx)
  );

  assign tbState = state;
endmodule

// File: tb/test_refsel_holdover.sv
`timescale 1ns/1ps
module test_refsel_holdover;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  refTick = '0;
  logic [3:0]  regAddr = '0;
  logic        regWr = 1'b0, regRd = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [1:0]  tbState, selRef;

  int  checks = 0, failures = 0;
  bit  finished = 1'b0;
  bit  refOn [3];
  bit  refBad [3];
  int  tickLeft [3];
  int  expSwitches = 0;

  always #10 clk = ~clk;

  refsel_holdover i_refsel_holdover (
    .clk(clk), .rstN(rstN), .refTick(refTick), .regAddr(regAddr), .regWr(regWr),
    .regRd(regRd), .regWdata(regWdata), .regRdata(regRdata),
    .tbState(tbState), .selRef(selRef)
  );

  function automatic int goodGap();
    return 18 + int'($urandom_range(0, 4));
  endfunction

  function automatic logic [7:0] hdr(input int rsn, input int st, input int rf);
    return {1'b1, 1'b0, 2'(rsn), 2'(st), 2'(rf)};
  endfunction

  // marker generators: good gaps 18..22 around a period of 20, bad gap 15
  initial begin
    for (int i = 0; i < 3; i++) begin refOn[i] = 0; refBad[i] = 0; tickLeft[i] = 0; end
    forever begin
      @(negedge clk);
      for (int i = 0; i < 3; i++) begin
        refTick[i] = 1'b0;
        if (refOn[i]) begin
          tickLeft[i]--;
          if (tickLeft[i] <= 0) begin
            refTick[i] = 1'b1;
            tickLeft[i] = refBad[i] ? 15 : goodGap();
          end
        end
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); regAddr = a; regWdata = d; regWr = 1'b1;
    @(negedge clk); regWr = 1'b0;
  endtask

  task automatic readReg(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); regAddr = a; regRd = 1'b1;
    #2 d = regRdata;
    @(negedge clk); regRd = 1'b0;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic enableRef(input int i, input bit bad);
    refBad[i] = bad; tickLeft[i] = bad ? 15 : goodGap(); refOn[i] = 1;
  endtask

  task automatic checkSel(input string req, input int st, input int rf);
    #2;
    chk({req, " state"}, 32'(tbState), 32'(st));
    chk({req, " selRef"}, 32'(selRef), 32'(rf));
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    logic [31:0] d, d2, t1, t2;
    void'($urandom(32'd4711));
    waitCyc(5);
    rstN = 1'b1;
    waitCyc(2);
    // R1 reset state
    checkSel("R1 reset", 0, 0);
    readReg(4'h4, d); chk("R1 holdEntries reset", d, 0);
    readReg(4'h5, d); chk("R1 switchCount reset", d, 0);
    readReg(4'h8, d); chk("R1 log status reset", d, 0);
    readReg(4'h9, d); chk("R9 empty log read", d, 0);

    writeReg(4'h0, 20); writeReg(4'h1, 2); writeReg(4'h2, 3);
    readReg(4'h0, d); chk("R2 period readback", d, 20);

    // R2 qualification needs several intervals; R10 exit from holdover
    enableRef(1, 0);
    waitCyc(40);
    checkSel("R2 not yet qualified", 0, 0);
    waitCyc(150);
    checkSel("R10 lock on ref1", 1, 1);
    expSwitches++;
    readReg(4'h5, d); chk("R8 switchCount", d, 32'(expSwitches));
    readReg(4'h7, d); chk("R8 lastReason", d, 1);
    readReg(4'h4, d); chk("R8 holdEntries", d, 0);
    readReg(4'h9, d);  chk("R7 entry switch hdr", {24'b0, d[31:24]}, {24'b0, hdr(1, 2, 1)});
    readReg(4'h9, d2); chk("R7 entry lock hdr", {24'b0, d2[31:24]}, {24'b0, hdr(3, 1, 1)});
    chk("R5 switch length by timestamps", 32'(d2[23:0] - d[23:0]), 4);
    readReg(4'h6, t1); waitCyc(10); readReg(4'h6, t2);
    chk("R4 holdTime frozen in LOCK", t2, t1);

    // R10 preemption by a higher-priority source
    enableRef(0, 0);
    waitCyc(160);
    checkSel("R10 preempt to ref0", 1, 0);
    expSwitches++;
    readReg(4'h5, d); chk("R10 switchCount", d, 32'(expSwitches));
    readReg(4'h7, d); chk("R10 lastReason", d, 1);
    readReg(4'h9, d); chk("R7 preempt entry", {24'b0, d[31:24]}, {24'b0, hdr(1, 2, 0)});
    readReg(4'h9, d); chk("R7 preempt lock entry", {24'b0, d[31:24]}, {24'b0, hdr(3, 1, 0)});

    // R6 forced switch to a lower-priority qualified source, then pinned
    writeReg(4'h3, 1);
    waitCyc(20);
    checkSel("R6 forced to ref1", 1, 1);
    expSwitches++;
    readReg(4'h7, d); chk("R6 lastReason forced", d, 2);
    waitCyc(200);
    checkSel("R6 pinned despite ref0", 1, 1);
    readReg(4'h9, d); chk("R7 forced entry", {24'b0, d[31:24]}, {24'b0, hdr(2, 2, 1)});
    readReg(4'h9, d); chk("R7 forced lock entry", {24'b0, d[31:24]}, {24'b0, hdr(3, 1, 1)});

    // R6 force toward an unqualified input is ignored
    writeReg(4'h3, 2);
    waitCyc(20);
    checkSel("R6 unqualified force ignored", 1, 1);
    readReg(4'h5, d); chk("R6 switchCount unchanged", d, 32'(expSwitches));
    readReg(4'h8, d); chk("R6 no log entry", d, 0);

    // R3 loss of ref1 fails over to ref0
    refOn[1] = 0;
    waitCyc(100);
    checkSel("R3 failover to ref0", 1, 0);
    expSwitches++;
    readReg(4'h7, d); chk("R3 lastReason lost", d, 0);
    readReg(4'h5, d); chk("R3 switchCount", d, 32'(expSwitches));

    // R4 loss with nothing left enters holdover
    refOn[0] = 0;
    waitCyc(100);
    checkSel("R4 holdover", 0, 0);
    readReg(4'h4, d); chk("R4 holdEntries", d, 1);
    readReg(4'h6, t1); waitCyc(38); readReg(4'h6, t2);
    chk("R4 holdTime rate", t2 - t1, 40);

    // R2 input at the wrong rate never qualifies
    enableRef(2, 1);
    waitCyc(300);
    checkSel("R2 bad rate stays in holdover", 0, 0);
    readReg(4'h8, d); chk("R9 count before overflow", d, 3);

    // R9 overflow: switch event fills the FIFO, settle event is dropped
    refBad[2] = 0;
    waitCyc(200);
    checkSel("R10 lock on ref2", 1, 2);
    expSwitches++;
    readReg(4'h8, d); chk("R9 overflow flagged", d, 32'h104);
    readReg(4'h8, d); chk("R9 overflow cleared by read", d, 32'h004);

    // R9 push and pop in the same cycle on a full FIFO
    enableRef(1, 0);
    waitCyc(200);
    checkSel("R10 preempt to ref1", 1, 1);
    expSwitches++;
    writeReg(4'h3, 2);
    expSwitches++;
    waitCyc(2);
    readReg(4'h9, d); chk("R9 oldest entry on same-cycle pop", {24'b0, d[31:24]}, {24'b0, hdr(0, 2, 0)});
    readReg(4'h8, d); chk("R9 count after push+pop", d, 32'h104);
    readReg(4'h9, d); chk("R9 entry 2", {24'b0, d[31:24]}, {24'b0, hdr(3, 1, 0)});
    readReg(4'h9, d); chk("R9 entry 3 holdover", {24'b0, d[31:24]}, {24'b0, hdr(0, 0, 0)});
    readReg(4'h9, d); chk("R9 entry 4", {24'b0, d[31:24]}, {24'b0, hdr(1, 2, 2)});
    readReg(4'h9, d); chk("R9 tail is same-cycle push", {24'b0, d[31:24]}, {24'b0, hdr(3, 1, 2)});
    readReg(4'h9, d); chk("R9 drained", d, 0);
    checkSel("R6 forced to ref2", 1, 2);
    readReg(4'h5, d); chk("R8 final switchCount", d, 32'(expSwitches));
    readReg(4'h7, d); chk("R8 final lastReason", d, 2);

    finishRun();
  end
endmodule